// File: doc/BRIEF.md
# Bus Target Register Window Controller

This block is the target side of a 32-bit PCI bus for one small memory-mapped window of registers. It samples the shared bus lines on every rising clock edge. On the first clock on which the frame strobe is seen low, it takes the command from the shared command/byte-enable lines and the address from the address/data lines. A memory read or memory write that falls inside the window is claimed. Any other cycle is passed over until the bus is idle again.

Each claimed transfer has one or more data phases. In every phase the target waits a programmable number of clocks and then drives its ready strobe low. The phase completes on the edge where both ready strobes are sampled low. Writes merge the bus data into the addressed register lane by lane under the active-low byte enables. Reads put the addressed register on the output bus while the target's ready strobe is low. The register index steps by one word after every completed phase and wraps inside the window. The transfer ends with the phase during which the frame strobe is high.

Top module: `pcit_window`

## Requirements
- R1: After reset, trdy_n is 1, ad_oe is 0, and every register in the window reads back as zero.
- R2: A cycle is claimed only when, on the address clock, cbe_n is 4'b0110 (memory read) or 4'b0111 (memory write) and ad_in[31:IW+2] matches the window base (IW = log2 of the register count). Any other command or address never lowers trdy_n and changes no register.
- R3: In each data phase, trdy_n falls on the (wait_cfg+1)-th rising edge after the address clock or after the previous completing edge.
- R4: A data phase completes only on an edge where trdy_n and irdy_n are both low. trdy_n returns high on the edge that follows that edge.
- R5: A write changes, on the completing edge only, the byte lanes whose enable is 0. cbe_n[0] gates bits 7:0 and cbe_n[3] gates bits 31:24.
- R6: During a read, ad_oe is 1 exactly while trdy_n is low, and ad_out then holds the addressed register.
- R7: Each completed phase advances the register index by one (the byte address by 4). The index wraps modulo the register count.
- R8: A phase that completes while frame_n is high ends the transfer. A new address clock is accepted only after frame_n and irdy_n have both been sampled high on the same edge.
- R9: While trdy_n is low and irdy_n is high, trdy_n stays low, and the data on the bus at that time is not committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Transfer framing strobe, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| cbe_n | input | 4 | Command on the address clock, byte enables during data phases |
| ad_in | input | 32 | Address/data lines as seen at the target |
| wait_cfg | input | WAITW | Wait clocks inserted before trdy_n in each phase |
| trdy_n | output | 1 | Target ready, active low |
| ad_out | output | 32 | Read data to the bus |
| ad_oe | output | 1 | Output enable for ad_out |

## Verification
The bench uses the default build: eight registers at base 0x1000 and a 3-bit wait count. It steps wait_cfg across the whole range 0 to 7, so the TRDY# delay is measured at both ends of its range. With eight registers, a four-beat burst that starts at index 6 wraps to index 1, which exercises the index roll-over. The small window also lets an address a few hundred bytes above the base serve as a miss without leaving the 32-bit space.

// File: rtl/pcit_window.sv
module pcit_window #(
  parameter logic [31:0] BASE_ADDR = 32'h0000_1000,
  parameter int NREGS = 8,
  parameter int WAITW = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_n,
  input  logic             irdy_n,
  input  logic [3:0]       cbe_n,
  input  logic [31:0]      ad_in,
  input  logic [WAITW-1:0] wait_cfg,
  output logic             trdy_n,
  output logic [31:0]      ad_out,
  output logic             ad_oe
);

  localparam int IW = $clog2(NREGS);
  localparam logic [3:0] CMD_MRD = 4'b0110;
  localparam logic [3:0] CMD_MWR = 4'b0111;

  typedef enum logic [1:0] {S_IDLE, S_DATA, S_DRAIN} st_t;

  st_t             st;
  logic            is_rd;
  logic [IW-1:0]   idx;
  logic [WAITW-1:0] wcnt;
  logic            trdy_q;
  logic [31:0]     regs [NREGS];

  wire in_win = (ad_in[31:IW+2] == BASE_ADDR[31:IW+2]);
  wire is_mem = (cbe_n == CMD_MRD) || (cbe_n == CMD_MWR);
  wire done   = (st == S_DATA) && !trdy_q && !irdy_n;

  assign trdy_n = trdy_q;
  assign ad_out = regs[idx];
  assign ad_oe  = (st == S_DATA) && is_rd && !trdy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      is_rd  <= 1'b0;
      idx    <= '0;
      wcnt   <= '0;
      trdy_q <= 1'b1;
    end else begin
      case (st)
        S_IDLE: if (!frame_n) begin
          if (in_win && is_mem) begin
            st    <= S_DATA;
            is_rd <= (cbe_n == CMD_MRD);
            idx   <= ad_in[IW+1:2];
            wcnt  <= '0;
          end else begin
            st <= S_DRAIN;
          end
        end
        S_DATA: begin
          if (trdy_q) begin
            if (wcnt == wait_cfg) trdy_q <= 1'b0;
            else wcnt <= wcnt + 1'b1;
          end else if (!irdy_n) begin
            trdy_q <= 1'b1;
            wcnt   <= '0;
            idx    <= idx + 1'b1;
            if (frame_n) st <= S_DRAIN;
          end
        end
        S_DRAIN: if (frame_n && irdy_n) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < NREGS; g++) regs[g] <= '0;
    end else if (done && !is_rd) begin
      for (int b = 0; b < 4; b++)
        if (!cbe_n[b]) regs[idx][8*b +: 8] <= ad_in[8*b +: 8];
    end
  end

  // R4
  trdy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> trdy_n);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_DATA) && !trdy_n && irdy_n) |=> (!trdy_n && $stable(idx)));

  // R6
  oe_with_trdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> !trdy_n);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_DATA) |-> (trdy_n && !ad_oe));

  // R8
  no_reentry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_DRAIN) && !(frame_n && irdy_n)) |=> (st == S_DRAIN));

  // R7
  burst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (idx == IW'($past(idx) + 1'b1)));

endmodule

// File: tb/pcit_window_tb.sv
module pcit_window_tb;
  localparam logic [31:0] BASE = 32'h0000_1000;
  localparam logic [3:0] MRD = 4'b0110;
  localparam logic [3:0] MWR = 4'b0111;

  // {idx[2:0], be_n[3:0], wdata[31:0], expected readback[31:0]}
  localparam int NV = 8;
  localparam logic [70:0] VEC [NV] = '{
    {3'd0, 4'b0000, 32'h1122_3344, 32'h1122_3344},
    {3'd0, 4'b1110, 32'hAABB_CCDD, 32'h1122_33DD},
    {3'd0, 4'b0111, 32'h9988_7766, 32'h9922_33DD},
    {3'd1, 4'b1111, 32'hFFFF_FFFF, 32'h0000_0000},
    {3'd1, 4'b1001, 32'h1234_5678, 32'h0034_5600},
    {3'd7, 4'b0000, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
    {3'd2, 4'b1100, 32'hCAFE_F00D, 32'h0000_F00D},
    {3'd7, 4'b1010, 32'h0102_0304, 32'hDE02_BE04}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_n = 1'b1, irdy_n = 1'b1;
  logic [3:0] cbe_n = 4'hF;
  logic [31:0] ad_in = '0;
  logic [2:0] wait_cfg = '0;
  logic trdy_n, ad_oe;
  logic [31:0] ad_out;

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  logic [31:0] bd [8];
  logic [3:0]  bb [8];

  always #10 clk = ~clk;

  pcit_window u_dut (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .cbe_n(cbe_n), .ad_in(ad_in), .wait_cfg(wait_cfg),
    .trdy_n(trdy_n), .ad_out(ad_out), .ad_oe(ad_oe)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input bit wr, input int sidx, input int n, input int w, input bit stall);
    int cnt;
    wait_cfg = w[2:0];
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b1;
    cbe_n = wr ? MWR : MRD;
    ad_in = BASE + 32'(4 * sidx);
    for (int b = 0; b < n; b++) begin
      @(negedge clk);
      frame_n = (b == n - 1);
      cbe_n = wr ? bb[b] : 4'b0000;
      irdy_n = stall;
      ad_in = stall ? 32'h5A5A_A5A5 : (wr ? bd[b] : 32'h0);
      chk(trdy_n == 1'b1, "R4 trdy high at phase start", 32'(trdy_n), 32'd1);
      cnt = 0;
      while (trdy_n && cnt < 20) begin
        @(negedge clk);
        cnt++;
      end
      chk(cnt == w + 1, "R3 wait clocks before trdy", 32'(cnt), 32'(w + 1));
      if (!wr) begin
        chk(ad_oe == 1'b1, "R6 ad_oe with trdy on read", 32'(ad_oe), 32'd1);
        chk(ad_out == bd[b], "R6/R7 read data", ad_out, bd[b]);
      end
      if (stall) begin
        repeat (2) begin
          @(negedge clk);
          chk(trdy_n == 1'b0, "R9 trdy held during irdy stall", 32'(trdy_n), 32'd0);
        end
        irdy_n = 1'b0;
        ad_in = wr ? bd[b] : 32'h0;
      end
    end
    @(negedge clk);
    frame_n = 1'b1; irdy_n = 1'b1; cbe_n = 4'hF; ad_in = '0;
    chk(trdy_n == 1'b1 && ad_oe == 1'b0, "R4 release after last phase",
        {30'd0, trdy_n, ad_oe}, 32'd2);
  endtask

  task automatic rd1(input int idx, input logic [31:0] exp, input int w);
    bd[0] = exp;
    xfer(1'b0, idx, 1, w, 1'b0);
  endtask

  task automatic wr1(input int idx, input logic [31:0] d, input logic [3:0] be, input int w, input bit stall);
    bd[0] = d; bb[0] = be;
    xfer(1'b1, idx, 1, w, stall);
  endtask

  task automatic miss(input logic [3:0] cmd, input logic [31:0] addr, input string tag);
    bit quiet;
    quiet = 1'b1;
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b1; cbe_n = cmd; ad_in = addr;
    @(negedge clk);
    frame_n = 1'b1; irdy_n = 1'b0; cbe_n = 4'h0; ad_in = 32'hFFFF_FFFF;
    repeat (10) begin
      @(negedge clk);
      if (!trdy_n || ad_oe) quiet = 1'b0;
    end
    chk(quiet, tag, 32'(quiet), 32'd1);
    frame_n = 1'b1; irdy_n = 1'b1; cbe_n = 4'hF;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(trdy_n == 1'b1 && ad_oe == 1'b0, "R1 reset outputs", {30'd0, trdy_n, ad_oe}, 32'd2);
    rst_n = 1'b1;
    @(negedge clk);
    rd1(3, 32'h0, 0);   // R1 registers clear

    for (int i = 0; i < NV; i++) begin
      logic [70:0] v;
      v = VEC[i];
      wr1(int'(v[70:68]), v[63:32], v[67:64], i, i == 2);   // R5, R3, R9
      rd1(int'(v[70:68]), v[31:0], 7 - i);                  // R5, R6
    end

    // R7 burst wraps from index 6 to index 1
    for (int b = 0; b < 4; b++) begin
      bd[b] = 32'hA000_0000 + 32'(b);
      bb[b] = 4'b0000;
    end
    xfer(1'b1, 6, 4, 1, 1'b0);
    xfer(1'b0, 6, 4, 2, 1'b0);
    rd1(2, 32'h0000_F00D, 0);   // R7 untouched neighbour

    // R2 misses: wrong command, out-of-window address
    miss(4'b0011, BASE + 32'h8, "R2 io write ignored");
    miss(MWR, BASE + 32'h100, "R2 out-of-window write ignored");
    miss(MRD, BASE - 32'h4, "R2 out-of-window read ignored");
    rd1(2, 32'h0000_F00D, 3);

    // R9 stalled read
    bd[0] = 32'hA000_0001;
    xfer(1'b0, 7, 1, 4, 1'b1);

    // R8 no new address phase until frame_n and irdy_n both high
    wait_cfg = 3'd0;
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b1; cbe_n = MWR; ad_in = BASE + 32'h14;
    @(negedge clk);
    frame_n = 1'b1; irdy_n = 1'b0; cbe_n = 4'h0; ad_in = 32'h7777_8888;
    while (trdy_n) @(negedge clk);
    @(negedge clk);
    frame_n = 1'b0; cbe_n = MWR; ad_in = BASE + 32'h10;
    @(negedge clk);
    cbe_n = 4'h0; ad_in = 32'h4444_4444;
    begin
      bit quiet;
      quiet = 1'b1;
      repeat (6) begin
        @(negedge clk);
        if (!trdy_n) quiet = 1'b0;
      end
      chk(quiet, "R8 address while irdy low refused", 32'(quiet), 32'd1);
    end
    frame_n = 1'b1; irdy_n = 1'b1; cbe_n = 4'hF;
    @(negedge clk);
    rd1(5, 32'h7777_8888, 0);   // R8 last phase of previous transfer landed
    rd1(4, 32'h0, 1);           // R8 refused write left register clear

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule